// File: doc/BRIEF.md
# Reservation-Station Scheduler with Result Broadcast Bus

This block is the out-of-order execution core of an arithmetic pipeline. It accepts one operation per cycle, in program order, from an upstream instruction queue. Each operation names a destination register and two source registers. The block places the operation in a free station of the matching class: three stations for add/subtract and two for multiply/divide. At that point each source is renamed. The station takes either the register's current value or the tag of the station that will produce that value. A station starts its fixed-latency execution once both operands are present. Operations therefore finish out of program order.

Finished results leave on a single broadcast bus that carries a 4-bit station tag and 64 data bits. Every waiting station and every register whose pending-writer tag equals the broadcast tag takes the data. The producing station then becomes free. Because only the most recent writer of a register is recorded, write-after-read and write-after-write conflicts resolve without a reorder buffer. The arithmetic treats operands as 64-bit unsigned integers, standing in for the floating-point units.

For checking, the register file can be read through a combinational read port.

Top module: `rsv_core`

## Requirements
- R1: After reset, register i reads back the value i, `cdbValid` is low, and `issueReady` is high for both operation classes.
- R2: `issueReady` is high exactly when a station of the offered class is free. Opcodes 0 and 1 use the three add stations and opcodes 2 and 3 use the two multiply stations. An offer is taken only on a clock edge where `issueValid` and `issueReady` are both high.
- R3: After all operations drain, the registers equal the result of executing the accepted operations one at a time in issue order. The opcodes are: 0 computes src1+src2, 1 computes src1-src2 (two's-complement wrap), 2 gives the low 64 bits of src1*src2, and 3 gives unsigned src1/src2. A zero divisor gives all ones.
- R4: If both operands are available when an operation is accepted on edge k, its result is on the bus in the cycle after edge k+L and not earlier. L is 3 for add/subtract, 10 for multiply and 40 for divide. A station never executes while an operand is missing.
- R5: Add stations carry tags 1, 2 and 3. Multiply stations carry tags 4 and 5. Issue picks the lowest-tagged free station of its class. Tag 0 means "no pending writer" and never appears on the bus.
- R6: When several stations finish in the same cycle, the lowest tag is broadcast first. The others keep their results and broadcast in later cycles. A station is free again on the edge that ends its broadcast.
- R7: A register whose pending-writer tag was replaced by a later issue ignores the broadcast of the earlier writer. Only its latest writer updates it.
- R8: An operation accepted on the same edge that ends the broadcast of one of its source tags takes the broadcast value directly and does not wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | An operation is offered |
| issueOp | input | 2 | Opcode: 0 add, 1 subtract, 2 multiply, 3 divide |
| issueDst | input | 3 | Destination register |
| issueSrc1 | input | 3 | First source register |
| issueSrc2 | input | 3 | Second source register |
| issueReady | output | 1 | A station of the offered class is free |
| readIdx | input | 3 | Register read address |
| readData | output | 64 | Contents of register `readIdx` |
| cdbValid | output | 1 | A result is on the broadcast bus |
| cdbTag | output | 4 | Tag of the broadcasting station |
| cdbData | output | 64 | Broadcast result value |

## Verification
The hardest situations to reach are the ones that depend on exact cycle alignment. The first is two stations finishing in the same cycle. The second is an operation issuing in the very cycle its producer broadcasts. The bench reaches both by counting clock edges after a known issue. A multiply is followed seven cycles later by an add, so both finish together. A dependent add is offered exactly three edges after its producer, so it lands on the broadcast cycle. Renaming hazards come from back-to-back writes to one register in both slow-then-fast and fast-then-slow order, with readbacks taken between the two broadcasts.

// File: rtl/rsv_core_pkg.sv
package rsv_core_pkg;
  localparam int ADD_STATIONS = 3;
  localparam int MUL_STATIONS = 2;
  localparam int STATIONS     = ADD_STATIONS + MUL_STATIONS;
  localparam int TAG_W        = 4;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_MUL = 2'd2,
    OP_DIV = 2'd3
  } aluOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic [STATIONS-1:0] alloc;
    logic [STATIONS-1:0] grant;
    logic                bcast;
    logic [TAG_W-1:0]    bcastTag;
  } ctrlStrobe_t;
endpackage

// File: rtl/rsv_ctrl.sv
module rsv_ctrl
  import rsv_core_pkg::*;
#(
  parameter int LAT_ADD = 3,
  parameter int LAT_MUL = 10,
  parameter int LAT_DIV = 40
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      issueValid,
  input  logic                      issueIsMul,
  input  logic [STATIONS-1:0]       busyVec,
  input  logic [STATIONS-1:0]       readyVec,
  input  logic [STATIONS-1:0][1:0]  opVec,
  output logic                      issueReady,
  output ctrlStrobe_t               strobes
);
  localparam int LAT_HI  = (LAT_DIV > LAT_MUL) ? LAT_DIV : LAT_MUL;
  localparam int LAT_MAX = (LAT_HI > LAT_ADD) ? LAT_HI : LAT_ADD;
  localparam int CNT_W   = $clog2(LAT_MAX + 1);

  logic [STATIONS-1:0] classMask, freeMatch, pick;
  logic [STATIONS-1:0] started, done, startNow, grantVec;
  logic [CNT_W-1:0]    cnt [STATIONS];

  function automatic logic [CNT_W-1:0] latOf(input logic [1:0] op);
    case (aluOp_e'(op))
      OP_MUL:  latOf = CNT_W'(LAT_MUL - 1);
      OP_DIV:  latOf = CNT_W'(LAT_DIV - 1);
      default: latOf = CNT_W'(LAT_ADD - 1);
    endcase
  endfunction

  // class membership is fixed by station position
  for (genvar g = 0; g < STATIONS; g++) begin : g_class
    if (g < ADD_STATIONS) begin : g_add
      assign classMask[g] = ~issueIsMul;
    end else begin : g_mul
      assign classMask[g] = issueIsMul;
    end
  end

  assign freeMatch  = classMask & ~busyVec;
  assign issueReady = |freeMatch;

  always_comb begin
    logic found;
    pick  = '0;
    found = 1'b0;
    for (int i = 0; i < STATIONS; i++) begin
      if (freeMatch[i] && !found) begin
        pick[i] = 1'b1;
        found   = 1'b1;
      end
    end
  end

  assign strobes.alloc = (issueValid && issueReady) ? pick : '0;

  // execution timers
  always_comb begin
    for (int i = 0; i < STATIONS; i++) begin
      startNow[i] = busyVec[i] && readyVec[i] && !started[i];
      done[i]     = started[i] && (cnt[i] == '0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      started <= '0;
      for (int i = 0; i < STATIONS; i++) cnt[i] <= '0;
    end else begin
      for (int i = 0; i < STATIONS; i++) begin
        if (grantVec[i]) begin
          started[i] <= 1'b0;
        end else if (startNow[i]) begin
          started[i] <= 1'b1;
          cnt[i]     <= latOf(opVec[i]);
        end else if (started[i] && cnt[i] != '0) begin
          cnt[i] <= cnt[i] - 1'b1;
        end
      end
    end
  end

  // bus arbitration: lowest tag wins
  always_comb begin
    logic taken;
    grantVec         = '0;
    taken            = 1'b0;
    strobes.bcastTag = '0;
    for (int i = 0; i < STATIONS; i++) begin
      if (done[i] && !taken) begin
        grantVec[i]      = 1'b1;
        taken            = 1'b1;
        strobes.bcastTag = TAG_W'(i + 1);
      end
    end
  end

  assign strobes.grant = grantVec;
  assign strobes.bcast = |done;

  for (genvar g = 0; g < STATIONS; g++) begin : g_chk
    // R6: a finished result that lost arbitration stays finished
    p_hold_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done[g] && !grantVec[g] |=> done[g]);
    // R4: operands supplied by the datapath stay present during execution
    p_exec_operands_r4: assert property (@(posedge clk) disable iff (!rst_n)
      started[g] |-> readyVec[g]);
  end
endmodule

// File: rtl/rsv_datapath.sv
module rsv_datapath
  import rsv_core_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NUM_REGS = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  ctrlStrobe_t               strobes,
  input  logic [1:0]                issueOp,
  input  logic [$clog2(NUM_REGS)-1:0] issueDst,
  input  logic [$clog2(NUM_REGS)-1:0] issueSrc1,
  input  logic [$clog2(NUM_REGS)-1:0] issueSrc2,
  input  logic [$clog2(NUM_REGS)-1:0] readIdx,
  output logic [DATA_W-1:0]         readData,
  output logic [DATA_W-1:0]         cdbData,
  output logic [STATIONS-1:0]       busyVec,
  output logic [STATIONS-1:0]       readyVec,
  output logic [STATIONS-1:0][1:0]  opVec
);
  localparam int REG_W = $clog2(NUM_REGS);

  // station storage
  logic [STATIONS-1:0] busyQ;
  aluOp_e              opQ [STATIONS];
  logic [DATA_W-1:0]   vj  [STATIONS];
  logic [DATA_W-1:0]   vk  [STATIONS];
  logic [TAG_W-1:0]    qj  [STATIONS];
  logic [TAG_W-1:0]    qk  [STATIONS];

  // architectural state
  logic [DATA_W-1:0]   regFile [NUM_REGS];
  logic [TAG_W-1:0]    regStat [NUM_REGS];

  logic                issueFire;
  logic [TAG_W-1:0]    allocTag;
  logic [DATA_W-1:0]   src1Val, src2Val;
  logic [TAG_W-1:0]    src1Tag, src2Tag;

  assign issueFire = |strobes.alloc;

  always_comb begin
    allocTag = '0;
    for (int i = 0; i < STATIONS; i++)
      if (strobes.alloc[i]) allocTag = TAG_W'(i + 1);
  end

  // operand renaming with same-cycle bus bypass
  always_comb begin
    src1Val = regFile[issueSrc1];
    src1Tag = regStat[issueSrc1];
    if (src1Tag != '0) begin
      if (strobes.bcast && src1Tag == strobes.bcastTag) begin
        src1Val = cdbData;
        src1Tag = '0;
      end else begin
        src1Val = '0;
      end
    end
  end

  always_comb begin
    src2Val = regFile[issueSrc2];
    src2Tag = regStat[issueSrc2];
    if (src2Tag != '0) begin
      if (strobes.bcast && src2Tag == strobes.bcastTag) begin
        src2Val = cdbData;
        src2Tag = '0;
      end else begin
        src2Val = '0;
      end
    end
  end

  // stations: allocate, snoop, release
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busyQ <= '0;
      for (int i = 0; i < STATIONS; i++) begin
        opQ[i] <= OP_ADD;
        vj[i]  <= '0;
        vk[i]  <= '0;
        qj[i]  <= '0;
        qk[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < STATIONS; i++) begin
        if (strobes.alloc[i]) begin
          busyQ[i] <= 1'b1;
          opQ[i]   <= aluOp_e'(issueOp);
          vj[i]    <= src1Val;
          vk[i]    <= src2Val;
          qj[i]    <= src1Tag;
          qk[i]    <= src2Tag;
        end else if (strobes.grant[i]) begin
          busyQ[i] <= 1'b0;
        end else if (busyQ[i] && strobes.bcast) begin
          if (qj[i] == strobes.bcastTag) begin
            vj[i] <= cdbData;
            qj[i] <= '0;
          end
          if (qk[i] == strobes.bcastTag) begin
            vk[i] <= cdbData;
            qk[i] <= '0;
          end
        end
      end
    end
  end

  // register file and result status
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_REGS; r++) begin
        regFile[r] <= DATA_W'(r);
        regStat[r] <= '0;
      end
    end else begin
      for (int r = 0; r < NUM_REGS; r++) begin
        if (strobes.bcast && regStat[r] == strobes.bcastTag) begin
          regFile[r] <= cdbData;
          regStat[r] <= '0;
        end
        if (issueFire && issueDst == REG_W'(r)) regStat[r] <= allocTag;
      end
    end
  end

  // shared arithmetic for the granted station
  always_comb begin
    logic [DATA_W-1:0] selA, selB;
    aluOp_e            selOp;
    selA  = '0;
    selB  = '0;
    selOp = OP_ADD;
    for (int i = 0; i < STATIONS; i++) begin
      if (strobes.grant[i]) begin
        selA  = vj[i];
        selB  = vk[i];
        selOp = opQ[i];
      end
    end
    case (selOp)
      OP_ADD:  cdbData = selA + selB;
      OP_SUB:  cdbData = selA - selB;
      OP_MUL:  cdbData = selA * selB;
      default: cdbData = (selB == '0) ? '1 : selA / selB;
    endcase
  end

  always_comb begin
    for (int i = 0; i < STATIONS; i++) begin
      readyVec[i] = (qj[i] == '0) && (qk[i] == '0);
      opVec[i]    = opQ[i];
    end
  end

  assign busyVec  = busyQ;
  assign readData = regFile[readIdx];

  for (genvar g = 0; g < STATIONS; g++) begin : g_rs_chk
    // R2: control only allocates stations the datapath holds idle
    p_alloc_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      strobes.alloc[g] |-> !busyQ[g]);
    // R6: a station is released right after its broadcast
    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      strobes.grant[g] |=> !busyQ[g]);
    // R5: only an occupied station with both operands broadcasts its tag
    p_bcast_owner_r5: assert property (@(posedge clk) disable iff (!rst_n)
      strobes.bcast && strobes.bcastTag == TAG_W'(g + 1) |-> busyQ[g] && readyVec[g]);
  end

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg_chk
    // R7: a matching broadcast clears the pending tag unless renamed again
    p_status_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      strobes.bcast && regStat[r] == strobes.bcastTag &&
      !(issueFire && issueDst == REG_W'(r)) |=> regStat[r] == '0);
    // R7: a new issue always makes itself the latest writer
    p_rename_r7: assert property (@(posedge clk) disable iff (!rst_n)
      issueFire && issueDst == REG_W'(r) |=> regStat[r] == $past(allocTag));
  end
endmodule

// File: rtl/rsv_core.sv
module rsv_core
  import rsv_core_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NUM_REGS = 8,
  parameter int LAT_ADD  = 3,
  parameter int LAT_MUL  = 10,
  parameter int LAT_DIV  = 40
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        issueValid,
  input  logic [1:0]                  issueOp,
  input  logic [$clog2(NUM_REGS)-1:0] issueDst,
  input  logic [$clog2(NUM_REGS)-1:0] issueSrc1,
  input  logic [$clog2(NUM_REGS)-1:0] issueSrc2,
  output logic                        issueReady,
  input  logic [$clog2(NUM_REGS)-1:0] readIdx,
  output logic [DATA_W-1:0]           readData,
  output logic                        cdbValid,
  output logic [TAG_W-1:0]            cdbTag,
  output logic [DATA_W-1:0]           cdbData
);
  ctrlStrobe_t               strobes;
  logic [STATIONS-1:0]       busyVec, readyVec;
  logic [STATIONS-1:0][1:0]  opVec;

  rsv_ctrl #(
    .LAT_ADD(LAT_ADD), .LAT_MUL(LAT_MUL), .LAT_DIV(LAT_DIV)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .issueValid(issueValid),
    .issueIsMul(issueOp[1]),
    .busyVec   (busyVec),
    .readyVec  (readyVec),
    .opVec     (opVec),
    .issueReady(issueReady),
    .strobes   (strobes)
  );

  rsv_datapath #(
    .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobes  (strobes),
    .issueOp  (issueOp),
    .issueDst (issueDst),
    .issueSrc1(issueSrc1),
    .issueSrc2(issueSrc2),
    .readIdx  (readIdx),
    .readData (readData),
    .cdbData  (cdbData),
    .busyVec  (busyVec),
    .readyVec (readyVec),
    .opVec    (opVec)
  );

  assign cdbValid = strobes.bcast;
  assign cdbTag   = strobes.bcastTag;

  // R5: the bus never carries the empty tag or an unknown station
  p_tag_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cdbValid |-> (cdbTag != '0) && (cdbTag <= TAG_W'(STATIONS)));
endmodule

// File: tb/rsv_core_test.sv
module rsv_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issueValid = 1'b0;
  logic [1:0]  issueOp = 2'd0;
  logic [2:0]  issueDst = '0, issueSrc1 = '0, issueSrc2 = '0, readIdx = '0;
  logic        issueReady, cdbValid;
  logic [3:0]  cdbTag;
  logic [63:0] readData, cdbData;

  int checks = 0;
  int fails  = 0;
  logic [63:0] refReg [8];

  always #5 clk = ~clk;

  rsv_core uut (
    .clk(clk), .rst_n(rst_n), .issueValid(issueValid), .issueOp(issueOp),
    .issueDst(issueDst), .issueSrc1(issueSrc1), .issueSrc2(issueSrc2),
    .issueReady(issueReady), .readIdx(readIdx), .readData(readData),
    .cdbValid(cdbValid), .cdbTag(cdbTag), .cdbData(cdbData)
  );

  // {op, dst, src1, src2}
  localparam int NPROG = 12;
  localparam logic [10:0] PROG [NPROG] = '{
    {2'd2, 3'd1, 3'd3, 3'd4}, {2'd0, 3'd2, 3'd1, 3'd5},
    {2'd1, 3'd3, 3'd2, 3'd7}, {2'd3, 3'd4, 3'd2, 3'd5},
    {2'd2, 3'd5, 3'd4, 3'd6}, {2'd0, 3'd6, 3'd5, 3'd1},
    {2'd3, 3'd7, 3'd6, 3'd0}, {2'd1, 3'd0, 3'd4, 3'd3},
    {2'd0, 3'd1, 3'd1, 3'd1}, {2'd2, 3'd2, 3'd6, 3'd6},
    {2'd3, 3'd3, 3'd2, 3'd1}, {2'd0, 3'd4, 3'd7, 3'd5}
  };

  function automatic logic [63:0] refCalc(input logic [1:0] op, input logic [63:0] a, b);
    case (op)
      2'd0:    refCalc = a + b;
      2'd1:    refCalc = a - b;
      2'd2:    refCalc = a * b;
      default: refCalc = (b == 64'd0) ? '1 : a / b;
    endcase
  endfunction

  task automatic expect64(input string req, input string what, input logic [63:0] act, exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input int d, s1, s2);
    @(negedge clk);
    issueValid = 1'b1;
    issueOp    = op;
    issueDst   = 3'(d);
    issueSrc1  = 3'(s1);
    issueSrc2  = 3'(s2);
    while (!issueReady) @(negedge clk);
    @(posedge clk);
    #1 issueValid = 1'b0;
    refReg[d] = refCalc(op, refReg[s1], refReg[s2]);
  endtask

  task automatic readReg(input int idx, output logic [63:0] val);
    @(negedge clk);
    readIdx = 3'(idx);
    #1 val = readData;
  endtask

  task automatic compareAll(input string req);
    logic [63:0] v;
    for (int r = 0; r < 8; r++) begin
      readReg(r, v);
      expect64(req, $sformatf("reg%0d", r), v, refReg[r]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R3 watchdog: actual=hung expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] v, oldVal;
    for (int r = 0; r < 8; r++) refReg[r] = 64'(r);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    @(negedge clk);
    expect64("R1", "cdbValid", 64'(cdbValid), 64'd0);
    issueOp = 2'd0; #1 expect64("R1", "ready add", 64'(issueReady), 64'd1);
    issueOp = 2'd2; #1 expect64("R1", "ready mul", 64'(issueReady), 64'd1);
    compareAll("R1");

    // R3: program table against sequential model
    for (int n = 0; n < NPROG; n++)
      issue(PROG[n][10:9], int'(PROG[n][8:6]), int'(PROG[n][5:3]), int'(PROG[n][2:0]));
    repeat (400) @(posedge clk);
    compareAll("R3");

    // R4/R5: add latency and tag of first add station
    issue(2'd0, 1, 2, 3);
    repeat (2) @(posedge clk);
    #1 expect64("R4", "add early bus", 64'(cdbValid), 64'd0);
    @(posedge clk);
    #1 expect64("R4", "add bus valid", 64'(cdbValid), 64'd1);
    expect64("R5", "add tag", 64'(cdbTag), 64'd1);
    expect64("R3", "add data", cdbData, refReg[1]);
    repeat (4) @(posedge clk);

    // R4/R5: multiply latency and tag of first mul station
    issue(2'd2, 2, 3, 4);
    repeat (9) @(posedge clk);
    #1 expect64("R4", "mul early bus", 64'(cdbValid), 64'd0);
    @(posedge clk);
    #1 expect64("R4", "mul bus valid", 64'(cdbValid), 64'd1);
    expect64("R5", "mul tag", 64'(cdbTag), 64'd4);
    repeat (4) @(posedge clk);

    // R6: mul and add finish in the same cycle
    issue(2'd2, 6, 1, 2);
    repeat (6) @(posedge clk);
    issue(2'd0, 7, 3, 4);
    repeat (3) @(posedge clk);
    #1 expect64("R6", "first tag", 64'(cdbTag), 64'd1);
    expect64("R6", "first valid", 64'(cdbValid), 64'd1);
    @(posedge clk);
    #1 expect64("R6", "held tag", 64'(cdbTag), 64'd4);
    expect64("R6", "held valid", 64'(cdbValid), 64'd1);
    repeat (4) @(posedge clk);
    compareAll("R6");

    // R7: fast older writer, slow newer writer
    oldVal = refReg[5];
    issue(2'd0, 5, 1, 2);
    issue(2'd2, 5, 3, 4);
    repeat (5) @(posedge clk);
    readReg(5, v);
    expect64("R7", "stale broadcast ignored", v, oldVal);
    repeat (20) @(posedge clk);
    readReg(5, v);
    expect64("R7", "latest writer", v, refReg[5]);

    // R7: slow older writer, fast newer writer
    issue(2'd2, 6, 1, 1);
    issue(2'd0, 6, 2, 3);
    repeat (20) @(posedge clk);
    readReg(6, v);
    expect64("R7", "late old result ignored", v, refReg[6]);

    // R8: dependent issue on the broadcast cycle
    issue(2'd0, 1, 2, 3);
    repeat (3) @(posedge clk);
    #1 expect64("R8", "producer on bus", 64'(cdbValid), 64'd1);
    issue(2'd0, 4, 1, 1);
    repeat (10) @(posedge clk);
    readReg(4, v);
    expect64("R8", "bypassed operand", v, refReg[4]);

    // R2: stalls when a class is full
    issue(2'd3, 2, 5, 1);
    issue(2'd3, 3, 6, 1);
    @(negedge clk);
    issueOp = 2'd2; #1 expect64("R2", "mul full", 64'(issueReady), 64'd0);
    issueOp = 2'd0; #1 expect64("R2", "add free", 64'(issueReady), 64'd1);
    issue(2'd0, 4, 2, 0);
    issue(2'd1, 6, 3, 1);
    issue(2'd0, 7, 2, 3);
    @(negedge clk);
    issueOp = 2'd1; #1 expect64("R2", "add full", 64'(issueReady), 64'd0);
    repeat (120) @(posedge clk);
    @(negedge clk);
    issueOp = 2'd3; #1 expect64("R2", "mul freed", 64'(issueReady), 64'd1);
    compareAll("R3");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule